// File: doc/BRIEF.md
# Configurable Macrocell Register Stage

This block is one register cell of a programmable-logic array together with its pin and feedback paths. A static configuration vector decides how the cell stores data (plain D, toggle, JK, set/reset, or a transparent latch), which clock it listens to (one of several global clocks or a per-cell product-term clock), whether a product-term clock enable gates that clock, where its clear and preset come from, what drives the pin, what is fed back into the array, and what enables the pin driver.

The cell is modelled inside a fast system clock domain (`clk`). The selected cell clock is sampled on every system clock edge. A rising edge of the cell clock is seen when the sampled level is high and the level sampled one system cycle earlier was low. Clear and preset are level inputs and take effect at the next system clock edge. The sum term, the second product term and the output-enable inputs reach the pin outputs combinationally.

Top module: `macrocell_reg`

## Requirements
- R1: With storage mode 0 (and any mode code 5 to 7, which fall back to it), the stored bit takes `sum_in` at every detected rising edge of the selected cell clock and keeps its value otherwise. The new value is visible one system clock later.
- R2: Mode 1 toggles the stored bit on an edge when `sum_in` is 1. Mode 2 is JK with J=`sum_in` and K=`pt2_in`: 10 sets, 01 clears, 11 toggles, 00 holds. Mode 3 is set/reset with S=`sum_in` and R=`pt2_in`: 10 sets, 01 clears, 00 and 11 hold.
- R3: Mode 4 is a latch. While the selected cell clock is high (and not gated off), the stored bit follows `sum_in` one system clock later. While that clock is low, the stored bit holds.
- R4: Clock select field code k < 3 picks `gclk[k]`, code 3 picks `pt_clk`, and codes 4 to 7 fall back to `gclk[0]`. Edges on clocks that are not selected have no effect.
- R5: When the clock-enable bit is set and a global clock is selected, a low `pt_ce` makes the cell ignore clock edges and latch transparency. With `pt_clk` selected, `pt_ce` has no effect.
- R6: Clear source code 0 is never active, 1 uses `gclear`, 2 uses `pt_rst`, and 3 uses their OR. An active clear forces the stored bit to 0 at the next system clock and wins over preset.
- R7: Preset source code 1 uses `pt_pre`. Codes 0, 2 and 3 never preset. An active preset without clear forces the stored bit to 1.
- R8: With pin select 0, `pin_out` shows the stored bit. With pin select 1, `pin_out` is `sum_in` in the same cycle.
- R9: `fb_out` shows the stored bit when the feedback select is 0, and `sum_in` when it is 1, independent of the pin select.
- R10: The output-enable code drives `oe_out`: 0 gives 0 (the pin acts as an input), 1 gives 1, 2 gives `oe_pin[0]`, 3 gives `oe_pin[1]`, 4 gives `io_in`, 5 gives `pt_oe`, and 6 or 7 give 0.
- R11: A synchronous `rst` clears the stored bit and treats the cell clock as already high, so a clock held high across reset does not cause an edge.

Configuration layout of `cfg` (bit ranges): mode [2:0], clock select [5:3], clock-enable enable [6], clear source [8:7], preset source [10:9], pin select [11], feedback select [12], output-enable select [15:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at which the cell is sampled |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 16 | Static configuration vector |
| sum_in | input | 1 | Sum term (D, T, J or S input) |
| pt2_in | input | 1 | Second product term (K or R input) |
| gclk | input | 3 | Global clocks |
| pt_clk | input | 1 | Per-cell product-term clock |
| pt_ce | input | 1 | Product-term clock enable |
| gclear | input | 1 | Global clear |
| pt_rst | input | 1 | Product-term clear |
| pt_pre | input | 1 | Product-term preset |
| oe_pin | input | 2 | Dedicated output-enable inputs |
| io_in | input | 1 | I/O pin used as an enable input |
| pt_oe | input | 1 | Product-term output enable |
| pin_out | output | 1 | Pin data output |
| fb_out | output | 1 | Buried feedback |
| oe_out | output | 1 | Pin driver enable |

## Verification
The combinational results are due in the same cycle as the inputs that cause them. These results are `oe_out`, and `pin_out` and `fb_out` when they select `sum_in`. The stored bit changes one system clock after the sample in which the clock edge, latch level, clear or preset is present. The bench drives every input just after a falling edge of `clk`. It updates its own model of the stored bit at the following rising edge, and compares all three outputs at the next falling edge. The combinational paths are therefore checked against the inputs still applied, and the stored paths are checked against the state after exactly one register stage.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4
    } store_mode_e;

    typedef enum logic [1:0] {
        CLR_OFF  = 2'd0,
        CLR_GLB  = 2'd1,
        CLR_PT   = 2'd2,
        CLR_BOTH = 2'd3
    } clr_src_e;

    typedef enum logic [1:0] {
        PRE_OFF = 2'd0,
        PRE_PT  = 2'd1
    } pre_src_e;

    // Field order sets the bit layout: the first member is the most significant.
    typedef struct packed {
        logic [SEL_W-1:0] oe_sel;
        logic             fb_comb;
        logic             out_comb;
        logic [1:0]       pre_sel;
        logic [1:0]       clr_sel;
        logic             ce_en;
        logic [SEL_W-1:0] clk_sel;
        logic [2:0]       mode;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    function automatic store_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MODE_T;
            3'd2:    return MODE_JK;
            3'd3:    return MODE_SR;
            3'd4:    return MODE_LATCH;
            default: return MODE_D;
        endcase
    endfunction

    function automatic pre_src_e decode_pre(input logic [1:0] code);
        return (code == 2'd1) ? PRE_PT : PRE_OFF;
    endfunction

    // Edge-triggered next state for the four flip-flop flavours.
    function automatic logic ff_next(input store_mode_e mode, input logic cur,
                                     input logic a, input logic b);
        logic nxt;
        nxt = cur;
        case (mode)
            MODE_T:  nxt = cur ^ a;
            MODE_JK: begin
                case ({a, b})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    2'b11:   nxt = ~cur;
                    default: nxt = cur;
                endcase
            end
            MODE_SR: begin
                case ({a, b})
                    2'b10:   nxt = 1'b1;
                    2'b01:   nxt = 1'b0;
                    default: nxt = cur;
                endcase
            end
            default: nxt = a;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    clk_sel,
    input  logic                ce_en,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                pt_ce,
    output logic                lvl_ok,
    output logic                edge_ok
);

    localparam logic [SEL_W-1:0] PT_CODE = SEL_W'(NUM_GCLK);

    logic lvl;
    logic lvl_q;
    logic is_global;
    logic ce_ok;
    logic edge_raw;

    always_comb begin
        lvl       = gclk[0];
        is_global = 1'b1;
        if (clk_sel == PT_CODE) begin
            lvl       = pt_clk;
            is_global = 1'b0;
        end else begin
            for (int i = 0; i < NUM_GCLK; i++) begin
                if (clk_sel == SEL_W'(i)) lvl = gclk[i];
            end
        end
    end

    // Reset value 1: a clock already high when reset lifts is not an edge.
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl;
    end

    assign ce_ok    = !(is_global && ce_en) || pt_ce;
    assign edge_raw = lvl & ~lvl_q;
    assign edge_ok  = edge_raw & ce_ok;
    assign lvl_ok   = lvl & ce_ok;

    p_single_edge_r4: assert property (@(posedge clk) disable iff (rst)
        edge_raw |=> !edge_raw)
        else $error("edge detector fired twice in a row");

endmodule

// File: rtl/mc_async_ctl.sv
module mc_async_ctl
    import mc_pkg::*;
(
    input  logic [1:0] clr_sel,
    input  logic [1:0] pre_sel,
    input  logic       gclear,
    input  logic       pt_rst,
    input  logic       pt_pre,
    output logic       clr_act,
    output logic       pre_act
);

    clr_src_e clr_src;
    pre_src_e pre_src;

    assign clr_src = clr_src_e'(clr_sel);
    assign pre_src = decode_pre(pre_sel);

    always_comb begin
        case (clr_src)
            CLR_GLB:  clr_act = gclear;
            CLR_PT:   clr_act = pt_rst;
            CLR_BOTH: clr_act = gclear | pt_rst;
            default:  clr_act = 1'b0;
        endcase
        pre_act = (pre_src == PRE_PT) ? pt_pre : 1'b0;
    end

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  store_mode_e mode,
    input  logic        sum_in,
    input  logic        pt2_in,
    input  logic        edge_ok,
    input  logic        lvl_ok,
    input  logic        clr_act,
    input  logic        pre_act,
    output logic        q
);

    logic is_latch;
    assign is_latch = (mode == MODE_LATCH);

    // Clear beats preset; both beat any clock activity.
    always_ff @(posedge clk) begin
        if (rst)                 q <= 1'b0;
        else if (clr_act)        q <= 1'b0;
        else if (pre_act)        q <= 1'b1;
        else if (is_latch) begin
            if (lvl_ok)          q <= sum_in;
        end else if (edge_ok)    q <= ff_next(mode, q, sum_in, pt2_in);
    end

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (q == 1'b0))
        else $error("clear did not force 0");

    p_preset_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (pre_act && !clr_act) |=> (q == 1'b1))
        else $error("preset did not force 1");

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr_act && !pre_act && !edge_ok && !(is_latch && lvl_ok)) |=> $stable(q))
        else $error("stored bit moved without an event");

    p_latch_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (is_latch && lvl_ok && !clr_act && !pre_act) |=> (q == $past(sum_in)))
        else $error("latch did not follow data");

    p_d_load_r1: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_D) && edge_ok && !clr_act && !pre_act) |=> (q == $past(sum_in)))
        else $error("D load missed");

endmodule

// File: rtl/mc_out_sel.sv
module mc_out_sel
    import mc_pkg::*;
#(
    parameter int NUM_OE = 2
) (
    input  logic              q,
    input  logic              sum_in,
    input  logic              out_comb,
    input  logic              fb_comb,
    input  logic [SEL_W-1:0]  oe_sel,
    input  logic [NUM_OE-1:0] oe_pin,
    input  logic              io_in,
    input  logic              pt_oe,
    output logic              pin_out,
    output logic              fb_out,
    output logic              oe_out
);

    localparam logic [SEL_W-1:0] ON_CODE  = SEL_W'(1);
    localparam int               DED_BASE = 2;
    localparam logic [SEL_W-1:0] IO_CODE  = SEL_W'(DED_BASE + NUM_OE);
    localparam logic [SEL_W-1:0] PT_CODE  = SEL_W'(DED_BASE + NUM_OE + 1);

    assign pin_out = out_comb ? sum_in : q;
    assign fb_out  = fb_comb  ? sum_in : q;

    // Code 0 and all unused codes leave the driver disabled.
    always_comb begin
        oe_out = 1'b0;
        if (oe_sel == ON_CODE)      oe_out = 1'b1;
        else if (oe_sel == IO_CODE) oe_out = io_in;
        else if (oe_sel == PT_CODE) oe_out = pt_oe;
        else begin
            for (int i = 0; i < NUM_OE; i++) begin
                if (oe_sel == SEL_W'(DED_BASE + i)) oe_out = oe_pin[i];
            end
        end
    end

endmodule

// File: rtl/macrocell_reg.sv
module macrocell_reg
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 3,
    parameter int NUM_OE   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg,
    input  logic                sum_in,
    input  logic                pt2_in,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                pt_ce,
    input  logic                gclear,
    input  logic                pt_rst,
    input  logic                pt_pre,
    input  logic [NUM_OE-1:0]   oe_pin,
    input  logic                io_in,
    input  logic                pt_oe,
    output logic                pin_out,
    output logic                fb_out,
    output logic                oe_out
);

    cell_cfg_t   c;
    store_mode_e mode;
    logic        lvl_ok;
    logic        edge_ok;
    logic        clr_act;
    logic        pre_act;
    logic        q;

    assign c    = cell_cfg_t'(cfg);
    assign mode = decode_mode(c.mode);

    mc_clk_sel #(.NUM_GCLK(NUM_GCLK)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (c.clk_sel),
        .ce_en   (c.ce_en),
        .gclk    (gclk),
        .pt_clk  (pt_clk),
        .pt_ce   (pt_ce),
        .lvl_ok  (lvl_ok),
        .edge_ok (edge_ok)
    );

    mc_async_ctl u_async (
        .clr_sel (c.clr_sel),
        .pre_sel (c.pre_sel),
        .gclear  (gclear),
        .pt_rst  (pt_rst),
        .pt_pre  (pt_pre),
        .clr_act (clr_act),
        .pre_act (pre_act)
    );

    mc_store u_store (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .sum_in  (sum_in),
        .pt2_in  (pt2_in),
        .edge_ok (edge_ok),
        .lvl_ok  (lvl_ok),
        .clr_act (clr_act),
        .pre_act (pre_act),
        .q       (q)
    );

    mc_out_sel #(.NUM_OE(NUM_OE)) u_out (
        .q        (q),
        .sum_in   (sum_in),
        .out_comb (c.out_comb),
        .fb_comb  (c.fb_comb),
        .oe_sel   (c.oe_sel),
        .oe_pin   (oe_pin),
        .io_in    (io_in),
        .pt_oe    (pt_oe),
        .pin_out  (pin_out),
        .fb_out   (fb_out),
        .oe_out   (oe_out)
    );

endmodule

// File: tb/test_macrocell_reg.sv
module test_macrocell_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg = '0;
    logic        sum_in = 0, pt2_in = 0, pt_clk = 0, pt_ce = 0;
    logic        gclear = 0, pt_rst = 0, pt_pre = 0, io_in = 0, pt_oe = 0;
    logic [2:0]  gclk = '0;
    logic [1:0]  oe_pin = '0;
    logic        pin_out, fb_out, oe_out;

    int n_chk = 0;
    int n_fail = 0;
    logic mq = 1'b0;
    logic mprev = 1'b1;

    always #5 clk = ~clk;

    macrocell_reg i_macrocell_reg (
        .clk(clk), .rst(rst), .cfg(cfg), .sum_in(sum_in), .pt2_in(pt2_in),
        .gclk(gclk), .pt_clk(pt_clk), .pt_ce(pt_ce), .gclear(gclear),
        .pt_rst(pt_rst), .pt_pre(pt_pre), .oe_pin(oe_pin), .io_in(io_in),
        .pt_oe(pt_oe), .pin_out(pin_out), .fb_out(fb_out), .oe_out(oe_out)
    );

    function automatic logic [15:0] mk(input int mode, input int cs, input int ce,
                                       input int clr, input int pre, input int oc,
                                       input int fc, input int oe);
        return {3'(oe), 1'(fc), 1'(oc), 2'(pre), 2'(clr), 1'(ce), 3'(cs), 3'(mode)};
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Bench model of the stored bit, advanced once per system clock edge.
    task automatic model_step();
        logic lvl, glob, edg, ceok, clr, pre;
        int cs;
        int md;
        cs = int'(cfg[5:3]);
        md = int'(cfg[2:0]);
        glob = (cs != 3);
        lvl = (cs < 3) ? gclk[cs] : (cs == 3) ? pt_clk : gclk[0];
        edg = lvl && !mprev;
        ceok = (glob && cfg[6]) ? pt_ce : 1'b1;
        case (int'(cfg[8:7]))
            1: clr = gclear;
            2: clr = pt_rst;
            3: clr = gclear || pt_rst;
            default: clr = 1'b0;
        endcase
        pre = (cfg[10:9] == 2'd1) ? pt_pre : 1'b0;
        if (rst) begin
            mq = 1'b0;
            mprev = 1'b1;
            return;
        end
        if (clr) mq = 1'b0;
        else if (pre) mq = 1'b1;
        else if (md == 4) begin
            if (lvl && ceok) mq = sum_in;
        end else if (edg && ceok) begin
            case (md)
                1: mq = mq ^ sum_in;
                2: mq = (sum_in && pt2_in) ? !mq : sum_in ? 1'b1 : pt2_in ? 1'b0 : mq;
                3: mq = (sum_in && !pt2_in) ? 1'b1 : (!sum_in && pt2_in) ? 1'b0 : mq;
                default: mq = sum_in;
            endcase
        end
        mprev = lvl;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [15:0] c);
        cfg = c;
        rst = 1'b1;
        cyc();
        rst = 1'b0;
    endtask

    // One low and one high cycle on source 0..2 (global) or 3 (product-term clock).
    task automatic pulse(input int src);
        if (src == 3) pt_clk = 1'b0; else gclk[src] = 1'b0;
        cyc();
        if (src == 3) pt_clk = 1'b1; else gclk[src] = 1'b1;
        cyc();
    endtask

    task automatic check_all();
        logic ep, ef, eo;
        ep = cfg[11] ? sum_in : mq;
        ef = cfg[12] ? sum_in : mq;
        case (int'(cfg[15:13]))
            1: eo = 1'b1;
            2: eo = oe_pin[0];
            3: eo = oe_pin[1];
            4: eo = io_in;
            5: eo = pt_oe;
            default: eo = 1'b0;
        endcase
        chk("R8 pin_out", pin_out, ep);
        chk("R9 fb_out", fb_out, ef);
        chk("R10 oe_out", oe_out, eo);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c311));
        @(negedge clk);

        // R11: clock held high through reset gives no edge; state is 0.
        gclk[0] = 1'b1; sum_in = 1'b1;
        do_reset(mk(0, 0, 0, 0, 0, 0, 0, 1));
        chk("R11 reset q", fb_out, 1'b0);
        chk("R11 reset pin", pin_out, 1'b0);
        cyc();
        chk("R11 no edge after reset", fb_out, 1'b0);

        // R1: D loads only on a rising edge.
        gclk = '0;
        do_reset(mk(0, 0, 0, 0, 0, 0, 0, 1));
        sum_in = 1'b1; pulse(0);
        chk("R1 D load 1", fb_out, 1'b1);
        sum_in = 1'b0; cyc();
        chk("R1 no edge hold", fb_out, 1'b1);
        pulse(0);
        chk("R1 D load 0", fb_out, 1'b0);
        cfg = mk(6, 0, 0, 0, 0, 0, 0, 1); sum_in = 1'b1; pulse(0);
        chk("R1 mode 6 acts as D", fb_out, 1'b1);

        // R2: T, JK, SR.
        gclk = '0;
        do_reset(mk(1, 0, 0, 0, 0, 0, 0, 1));
        sum_in = 1'b1; pulse(0);
        chk("R2 T toggle", fb_out, 1'b1);
        sum_in = 1'b0; pulse(0);
        chk("R2 T hold", fb_out, 1'b1);
        gclk = '0;
        do_reset(mk(2, 0, 0, 0, 0, 0, 0, 1));
        sum_in = 1'b1; pt2_in = 1'b1; pulse(0);
        chk("R2 JK toggle up", fb_out, 1'b1);
        pulse(0);
        chk("R2 JK toggle down", fb_out, 1'b0);
        gclk = '0;
        do_reset(mk(3, 0, 0, 0, 0, 0, 0, 1));
        sum_in = 1'b1; pt2_in = 1'b0; pulse(0);
        chk("R2 SR set", fb_out, 1'b1);
        pt2_in = 1'b1; pulse(0);
        chk("R2 SR both hold", fb_out, 1'b1);
        sum_in = 1'b0; pulse(0);
        chk("R2 SR reset", fb_out, 1'b0);
        pt2_in = 1'b0;

        // R3: latch follows while high, holds while low.
        gclk = '0;
        do_reset(mk(4, 0, 0, 0, 0, 0, 0, 1));
        gclk[0] = 1'b1; sum_in = 1'b1; cyc();
        chk("R3 latch follow 1", fb_out, 1'b1);
        sum_in = 1'b0; cyc();
        chk("R3 latch follow 0", fb_out, 1'b0);
        gclk[0] = 1'b0; sum_in = 1'b1; cyc(); cyc();
        chk("R3 latch hold", fb_out, 1'b0);

        // R4: clock source selection.
        gclk = '0;
        do_reset(mk(0, 2, 0, 0, 0, 0, 0, 1));
        sum_in = 1'b1; pulse(0);
        chk("R4 unselected clock ignored", fb_out, 1'b0);
        pulse(2);
        chk("R4 gclk2 selected", fb_out, 1'b1);
        gclk = '0;
        do_reset(mk(0, 7, 0, 0, 0, 0, 0, 1));
        pulse(2);
        chk("R4 code 7 ignores gclk2", fb_out, 1'b0);
        pulse(0);
        chk("R4 code 7 uses gclk0", fb_out, 1'b1);
        gclk = '0;
        do_reset(mk(0, 3, 0, 0, 0, 0, 0, 1));
        pulse(3);
        chk("R4 product-term clock", fb_out, 1'b1);

        // R5: clock enable.
        pt_clk = 1'b0; gclk = '0;
        do_reset(mk(0, 0, 1, 0, 0, 0, 0, 1));
        pt_ce = 1'b0; pulse(0);
        chk("R5 enable low blocks edge", fb_out, 1'b0);
        pt_ce = 1'b1; pulse(0);
        chk("R5 enable high passes edge", fb_out, 1'b1);
        do_reset(mk(0, 3, 1, 0, 0, 0, 0, 1));
        pt_ce = 1'b0; pulse(3);
        chk("R5 enable unused with pt clock", fb_out, 1'b1);
        pt_clk = 1'b0; gclk = '0;

        // R6 and R7: clear and preset.
        do_reset(mk(0, 0, 0, 2, 1, 0, 0, 1));
        pt_pre = 1'b1; cyc();
        chk("R7 preset sets", fb_out, 1'b1);
        pt_rst = 1'b1; cyc();
        chk("R6 clear beats preset", fb_out, 1'b0);
        pt_rst = 1'b0; pt_pre = 1'b0; cyc();
        chk("R6 stays cleared", fb_out, 1'b0);
        cfg = mk(0, 0, 0, 3, 1, 0, 0, 1);
        pt_pre = 1'b1; cyc(); pt_pre = 1'b0;
        gclear = 1'b1; cyc(); gclear = 1'b0;
        chk("R6 OR source uses gclear", fb_out, 1'b0);
        cfg = mk(0, 0, 0, 0, 1, 0, 0, 1);
        pt_pre = 1'b1; cyc(); pt_pre = 1'b0;
        gclear = 1'b1; pt_rst = 1'b1; cyc(); gclear = 1'b0; pt_rst = 1'b0;
        chk("R6 clear off ignored", fb_out, 1'b1);
        do_reset(mk(0, 0, 0, 0, 2, 0, 0, 1));
        pt_pre = 1'b1; cyc(); pt_pre = 1'b0;
        chk("R7 preset code 2 off", fb_out, 1'b0);

        // R8, R9, R10: directed output paths.
        do_reset(mk(0, 0, 0, 0, 0, 1, 0, 6));
        sum_in = 1'b1; #1;
        chk("R8 comb pin", pin_out, 1'b1);
        chk("R9 fb independent registered", fb_out, 1'b0);
        chk("R10 code 6 disabled", oe_out, 1'b0);
        cyc();

        // Random phase: outputs compared with the bench model every cycle.
        for (int blk = 0; blk < 60; blk++) begin
            do_reset(16'($urandom));
            for (int k = 0; k < 80; k++) begin
                sum_in = 1'($urandom); pt2_in = 1'($urandom);
                gclk = 3'($urandom); pt_clk = 1'($urandom);
                pt_ce = 1'($urandom); gclear = ($urandom % 8 == 0);
                pt_rst = ($urandom % 8 == 0); pt_pre = ($urandom % 6 == 0);
                oe_pin = 2'($urandom); io_in = 1'($urandom); pt_oe = 1'($urandom);
                cyc();
                check_all();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule